// File: doc/BRIEF.md
# Erasable Word Store with Busy Flag

This block is a synthesizable model of an in-system programmable non-volatile word store. It holds a parameterised number of words, 4096 words of 16 bits by default. A controller can do three things with it: read a word, program a word, and clear the whole array in one erase. A controller such as the one in a voice announcement recorder uses it this way. It asks for an erase, waits until the busy flag drops, and then programs sample words one address at a time.

Programming follows the rules of floating-gate storage. It can only pull bits from one to zero, so the stored word becomes the old contents ANDed with the new data. Only an erase puts bits back to one. Both erase and programming are slow, multi-cycle operations, and the busy output stays high while either one runs. Reads take a single cycle.

While the block is busy it ignores every request. The last read value stays on the read data port.

Top module: `flash_store`

## Requirements
- R1: After reset, `busy` is 0 and `mem_rdata` is all zeros.
- R2: When the block is idle, `mem_en`=1 with `mem_wr`=0 and `erase_req`=0 is a read. `mem_rdata` shows the word at `mem_addr` right after the next rising clock edge.
- R3: A completed erase leaves every word equal to all ones (16'hFFFF at default width).
- R4: An accepted erase holds `busy` high for exactly WORDS clock cycles. `busy` first goes high after the edge that accepts the request.
- R5: When the block is idle, `mem_en`=1 with `mem_wr`=1 starts a program. `busy` stays high for exactly PROG_CYCLES cycles, and the word at `mem_addr` then becomes its old value ANDed with `mem_wdata`.
- R6: While `busy` is high, reads and programs are ignored. No word changes because of them, and `mem_rdata` holds its value.
- R7: An erase request made while `busy` is high is ignored. A running erase is not restarted or lengthened by it.
- R8: When the block is idle, an erase request has priority over a read or program in the same cycle, and that access is dropped.
- R9: In a cycle with `mem_en`=0 and no erase request, nothing is started and `mem_rdata` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mem_en | input | 1 | Access request |
| mem_wr | input | 1 | 1 = program, 0 = read (used with mem_en) |
| mem_addr | input | $clog2(WORDS) | Word address |
| mem_wdata | input | DATA_W | Program data (can only clear bits) |
| mem_rdata | output | DATA_W | Registered read data |
| erase_req | input | 1 | Request a whole-array erase |
| busy | output | 1 | High while an erase or program is running |

## Verification
The bench builds the block with WORDS=64 and PROG_CYCLES=3. With these values a full erase runs in 64 cycles, so the erase can be started, interrupted by more requests and waited out several times in one run. The short array also lets the bench read back every address after each erase. This makes the exact erase length, the stepping to the last word, and a second erase request arriving mid-run all cheap to observe. The behavioural model tracks the whole array, the busy countdown and the read register, and it is compared with the outputs on every cycle.

// File: rtl/flash_pkg.sv
package flash_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PROG  = 2'd1,
    ST_ERASE = 2'd2
  } fst_e;
endpackage

// File: rtl/flash_rst_sync.sv
module flash_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sh_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge arst_n) begin
          if (!arst_n) sh_q[g] <= 1'b0;
          else         sh_q[g] <= 1'b1;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge arst_n) begin
          if (!arst_n) sh_q[g] <= 1'b0;
          else         sh_q[g] <= sh_q[g-1];
        end
      end
    end
  endgenerate

  assign srst_n = sh_q[STAGES-1];
endmodule

// File: rtl/flash_ctrl.sv
module flash_ctrl
  import flash_pkg::*;
#(
  parameter int WORDS       = 4096,
  parameter int DATA_W      = 16,
  parameter int PROG_CYCLES = 4,
  localparam int ADDR_W     = $clog2(WORDS),
  localparam int CNT_W      = $clog2(PROG_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              acc_wr,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] acc_wdata,
  input  logic              erase_req,
  output logic              busy,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_en,
  output logic              wr_and,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(WORDS - 1);
  localparam logic [CNT_W-1:0]  CNT_LOAD  = CNT_W'(PROG_CYCLES - 1);

  fst_e              state_q, state_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [ADDR_W-1:0] paddr_q;
  logic [DATA_W-1:0] pdata_q;
  logic              idle;
  logic              take_erase;
  logic              take_prog;
  logic              ld_prog;

  assign idle       = (state_q == ST_IDLE);
  assign take_erase = idle && erase_req;
  assign take_prog  = idle && !erase_req && acc_en && acc_wr;
  assign ld_prog    = take_prog;

  // next-state process
  always_comb begin
    state_d = state_q;
    ptr_d   = ptr_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: begin
        if (take_erase) begin
          state_d = ST_ERASE;
          ptr_d   = '0;
        end else if (take_prog) begin
          state_d = ST_PROG;
          cnt_d   = CNT_LOAD;
        end
      end
      ST_PROG: begin
        if (cnt_q == '0) state_d = ST_IDLE;
        else             cnt_d   = cnt_q - 1'b1;
      end
      ST_ERASE: begin
        if (ptr_q == LAST_ADDR) state_d = ST_IDLE;
        else                    ptr_d   = ptr_q + 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      ptr_q   <= ptr_d;
      cnt_q   <= cnt_d;
    end
  end

  // captured program operands, clock-enabled, no reset needed
  always_ff @(posedge clk) begin
    if (ld_prog) begin
      paddr_q <= acc_addr;
      pdata_q <= acc_wdata;
    end
  end

  assign busy    = !idle;
  assign rd_en   = idle && !erase_req && acc_en && !acc_wr;
  assign rd_addr = acc_addr;
  assign wr_en   = (state_q == ST_ERASE) || ((state_q == ST_PROG) && (cnt_q == '0));
  assign wr_and  = (state_q == ST_PROG);
  assign wr_addr = (state_q == ST_ERASE) ? ptr_q : paddr_q;
  assign wr_data = (state_q == ST_ERASE) ? '1 : pdata_q;

  AST_ERASE_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && erase_req) |=> (state_q == ST_ERASE && ptr_q == '0)); // R8
  AST_ERASE_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ERASE && ptr_q == LAST_ADDR) |=> !busy); // R4
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ERASE && erase_req && ptr_q != LAST_ADDR) |=> (ptr_q == $past(ptr_q) + 1'b1)); // R7
  AST_PROG_OPERANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PROG) |=> ($stable(paddr_q) && $stable(pdata_q))); // R6
  AST_PROG_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PROG && cnt_q != '0) |=> (state_q == ST_PROG && cnt_q == $past(cnt_q) - 1'b1)); // R5
endmodule

// File: rtl/flash_array.sv
module flash_array #(
  parameter int WORDS  = 4096,
  parameter int DATA_W = 16,
  localparam int ADDR_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              wr_en,
  input  logic              wr_and,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [WORDS];
  logic [DATA_W-1:0] merged;

  assign merged = wr_and ? (mem[wr_addr] & wr_data) : wr_data;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= merged;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= mem[rd_addr];
  end

  AST_ERASE_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_and) |=> (mem[$past(wr_addr)] == '1)); // R3
  AST_PROG_CLEAR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_and) |=> ((mem[$past(wr_addr)] & ~$past(mem[wr_addr])) == '0)); // R5
endmodule

// File: rtl/flash_store.sv
module flash_store #(
  parameter int WORDS       = 4096,
  parameter int DATA_W      = 16,
  parameter int PROG_CYCLES = 4,
  localparam int ADDR_W     = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mem_en,
  input  logic              mem_wr,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_wdata,
  output logic [DATA_W-1:0] mem_rdata,
  input  logic              erase_req,
  output logic              busy
);
  logic              srst_n;
  logic              rd_en;
  logic [ADDR_W-1:0] rd_addr;
  logic              wr_en;
  logic              wr_and;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;

  flash_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  flash_ctrl #(
    .WORDS       (WORDS),
    .DATA_W      (DATA_W),
    .PROG_CYCLES (PROG_CYCLES)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (srst_n),
    .acc_en    (mem_en),
    .acc_wr    (mem_wr),
    .acc_addr  (mem_addr),
    .acc_wdata (mem_wdata),
    .erase_req (erase_req),
    .busy      (busy),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .wr_en     (wr_en),
    .wr_and    (wr_and),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data)
  );

  flash_array #(
    .WORDS  (WORDS),
    .DATA_W (DATA_W)
  ) u_array (
    .clk     (clk),
    .rst_n   (srst_n),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .wr_en   (wr_en),
    .wr_and  (wr_and),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_data (mem_rdata)
  );

  AST_RDATA_FROZEN: assert property (@(posedge clk) disable iff (!srst_n)
    busy |=> $stable(mem_rdata)); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!srst_n)
    (!busy && !mem_en && !erase_req) |=> ($stable(mem_rdata) && !busy)); // R9
endmodule

// File: tb/test_flash_store.sv
module test_flash_store;
  localparam int WORDS = 64;
  localparam int DW    = 16;
  localparam int PROG  = 3;
  localparam int AW    = $clog2(WORDS);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mem_en = 1'b0;
  logic          mem_wr = 1'b0;
  logic [AW-1:0] mem_addr = '0;
  logic [DW-1:0] mem_wdata = '0;
  logic [DW-1:0] mem_rdata;
  logic          erase_req = 1'b0;
  logic          busy;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;
  string cur_req = "R1";

  // reference model state
  logic [DW-1:0] m_mem [WORDS];
  int            m_left = 0;
  int            m_kind = 0;   // 1 program, 2 erase
  int            m_ptr  = 0;
  int            m_paddr = 0;
  logic [DW-1:0] m_pdata = '0;
  logic [DW-1:0] m_rdata = '0;

  always #10 clk = ~clk;

  flash_store #(.WORDS(WORDS), .DATA_W(DW), .PROG_CYCLES(PROG)) i_flash_store (
    .clk(clk), .rst_n(rst_n), .mem_en(mem_en), .mem_wr(mem_wr),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .erase_req(erase_req), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // behavioural model, advanced on each rising edge
  always @(posedge clk) begin
    if (m_left > 0) begin
      if (m_kind == 2) begin
        m_mem[m_ptr] = '1;
        m_ptr++;
      end else if (m_left == 1) begin
        m_mem[m_paddr] = m_mem[m_paddr] & m_pdata;
      end
      m_left--;
    end else if (erase_req) begin
      m_kind = 2; m_left = WORDS; m_ptr = 0;
    end else if (mem_en && mem_wr) begin
      m_kind = 1; m_left = PROG; m_paddr = int'(mem_addr); m_pdata = mem_wdata;
    end else if (mem_en) begin
      m_rdata = m_mem[mem_addr];
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(busy === (m_left > 0), cur_req, "busy", {15'd0, busy}, {15'd0, m_left > 0});
      check(mem_rdata === m_rdata, cur_req, "rdata", mem_rdata, m_rdata);
    end
  end

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      mem_en = 1'b0; mem_wr = 1'b0; erase_req = 1'b0;
    end
  endtask

  task automatic do_read(input int a);
    @(negedge clk);
    mem_en = 1'b1; mem_wr = 1'b0; mem_addr = AW'(a); erase_req = 1'b0;
    @(negedge clk);
    mem_en = 1'b0;
  endtask

  // returns number of busy cycles observed after the request
  task automatic do_prog(input int a, input logic [DW-1:0] d, output int nbusy);
    @(negedge clk);
    mem_en = 1'b1; mem_wr = 1'b1; mem_addr = AW'(a); mem_wdata = d;
    @(negedge clk);
    mem_en = 1'b0; mem_wr = 1'b0;
    nbusy = 0;
    while (busy) begin nbusy++; @(negedge clk); end
  endtask

  task automatic do_erase(input bit reissue, output int nbusy);
    @(negedge clk);
    erase_req = 1'b1;
    @(negedge clk);
    erase_req = 1'b0;
    nbusy = 0;
    while (busy) begin
      nbusy++;
      erase_req = reissue && (nbusy == 20);
      @(negedge clk);
    end
    erase_req = 1'b0;
  endtask

  initial begin
    int nb;
    logic [DW-1:0] held;
    for (int i = 0; i < WORDS; i++) m_mem[i] = '0;
    repeat (3) @(negedge clk);
    check(busy === 1'b0, "R1", "busy in reset", {15'd0, busy}, 16'd0);
    check(mem_rdata === '0, "R1", "rdata in reset", mem_rdata, 16'd0);
    rst_n = 1'b1;
    idle_cycles(4);

    cur_req = "R4";
    do_erase(1'b0, nb);
    check(nb == WORDS, "R4", "erase busy length", DW'(nb), DW'(WORDS));

    cur_req = "R3";
    for (int a = 0; a < WORDS; a++) begin
      do_read(a);
      check(mem_rdata === 16'hFFFF, "R3", "erased word", mem_rdata, 16'hFFFF);
    end

    cur_req = "R5";
    do_prog(5, 16'h0F0F, nb);
    check(nb == PROG, "R5", "program busy length", DW'(nb), DW'(PROG));
    do_read(5);
    check(mem_rdata === 16'h0F0F, "R5", "first program", mem_rdata, 16'h0F0F);
    do_prog(5, 16'h3C3C, nb);
    do_read(5);
    check(mem_rdata === 16'h0C0C, "R5", "AND with old", mem_rdata, 16'h0C0C);
    do_prog(WORDS - 1, 16'h1234, nb);
    do_read(WORDS - 1);
    check(mem_rdata === 16'h1234, "R5", "last address", mem_rdata, 16'h1234);

    cur_req = "R2";
    do_read(0);
    check(mem_rdata === 16'hFFFF, "R2", "read after last program", mem_rdata, 16'hFFFF);

    cur_req = "R6";
    held = mem_rdata;
    @(negedge clk);
    mem_en = 1'b1; mem_wr = 1'b1; mem_addr = AW'(9); mem_wdata = 16'h00F0;
    @(negedge clk);
    mem_addr = AW'(10); mem_wdata = 16'h0000;
    @(negedge clk);
    mem_wr = 1'b0; mem_addr = AW'(5);
    check(mem_rdata === held, "R6", "rdata while busy", mem_rdata, held);
    @(negedge clk);
    mem_en = 1'b0;
    idle_cycles(2);
    do_read(10);
    check(mem_rdata === 16'hFFFF, "R6", "write while busy ignored", mem_rdata, 16'hFFFF);
    do_read(9);
    check(mem_rdata === 16'h00F0, "R6", "accepted program", mem_rdata, 16'h00F0);

    cur_req = "R9";
    held = mem_rdata;
    @(negedge clk);
    mem_en = 1'b0; mem_addr = AW'(5);
    idle_cycles(3);
    check(mem_rdata === held, "R9", "rdata with enable low", mem_rdata, held);
    check(busy === 1'b0, "R9", "no operation started", {15'd0, busy}, 16'd0);

    cur_req = "R7";
    do_erase(1'b1, nb);
    check(nb == WORDS, "R7", "reissued erase length", DW'(nb), DW'(WORDS));
    do_read(9);
    check(mem_rdata === 16'hFFFF, "R7", "word after erase", mem_rdata, 16'hFFFF);

    cur_req = "R8";
    do_prog(3, 16'h0000, nb);
    @(negedge clk);
    erase_req = 1'b1; mem_en = 1'b1; mem_wr = 1'b1; mem_addr = AW'(7); mem_wdata = 16'h0000;
    @(negedge clk);
    erase_req = 1'b0; mem_en = 1'b0; mem_wr = 1'b0;
    nb = 0;
    while (busy) begin nb++; @(negedge clk); end
    check(nb == WORDS, "R8", "erase wins busy length", DW'(nb), DW'(WORDS));
    do_read(7);
    check(mem_rdata === 16'hFFFF, "R8", "dropped program", mem_rdata, 16'hFFFF);
    do_read(3);
    check(mem_rdata === 16'hFFFF, "R8", "erase cleared word", mem_rdata, 16'hFFFF);

    idle_cycles(2);
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule